// File: doc/BRIEF.md
# Serial Port Register Block with Prioritised Interrupt Identification

This block is the software-visible register set of a simple serial port that has no FIFOs. A 32-bit bus slave on one side reads and writes eight word-wide registers. On the other side it exchanges whole bytes with a transmit stream and a receive stream. The bit serializer, the baud generator and the modem pin logic sit outside. Received bytes land in a single holding register. A second byte that arrives before software has read the first replaces it and raises an overrun flag.

One interrupt line is driven from four sources: line errors, received data, transmit holding empty and modem status. Each source has its own enable bit. The block grants the highest-priority enabled source and stores a matching cause code in an identification register. When nothing is pending, that register shows an idle code.

Top module: `sport_regs`

## Requirements
- R1: After a synchronous reset, line status reads 0x60 (bit 5 holding-empty and bit 6 transmitter-empty set), identification reads 0x01, every other register reads 0, `irq` is 0, `rx_ready` is 1 and `tx_valid` is 0.
- R2: The register index is the byte address shifted right by two. The map is: 0 data, 1 enable, 2 identification, 3 line control (8 bits), 4 modem control (8 bits), 5 line status, 6 modem status, 7 divisor (16 bits). Index 8 and above reads 0 and ignores writes. Unused upper bits read 0.
- R3: A write to index 0 raises `tx_valid` with `tx_byte` equal to the written low byte on the next cycle. Both hold until `tx_ready` is seen. While the byte is unaccepted, status bits 5 and 6 read 0.
- R4: An `rx_valid` strobe stores `rx_data` and sets data-ready (status bit 0). `rx_ready` is 1 exactly while data-ready is 0.
- R5: A read of index 0 returns the held byte and clears data-ready.
- R6: A byte that arrives while data-ready is set sets overrun (status bit 1). The new byte replaces the old one, and data-ready stays set.
- R7: `rx_perr`, `rx_ferr` and `rx_brk` that come with a byte set status bits 2, 3 and 4. A read of line status returns the bits and then clears bits 1 to 4 only.
- R8: Enable bits are: bit 0 data-ready, bit 1 holding-empty, bit 2 line error, bit 3 modem. The granted cause is the first enabled and active one, in the order line error, data-ready, holding-empty, modem.
- R9: Identification reads 0x06 for a line error, 0x04 for data-ready, 0x02 for holding-empty, 0x00 for modem, and 0x01 when no cause is granted. `irq` is 1 exactly when a cause is granted.
- R10: A modem cause is active when any of bits 3..0 of `modem_status` is set. Bits 7..4 do not cause an interrupt, and modem status reads back all 8 sampled bits.
- R11: Writes to identification, line status and modem status are ignored.
- R12: `irq` and identification reflect a register change one clock after the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the read |
| tx_valid | output | 1 | Transmit byte available |
| tx_byte | output | 8 | Transmit byte |
| tx_ready | input | 1 | Downstream takes the byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error with this byte |
| rx_ferr | input | 1 | Framing error with this byte |
| rx_brk | input | 1 | Break with this byte |
| rx_ready | output | 1 | Holding register is free |
| modem_status | input | 8 | Modem status from pin logic |
| irq | output | 1 | Interrupt request |

## Verification
Each state change lands on the edge that samples the access or strobe. Read data is due on that same edge. The interrupt line and the identification code are due one edge later, and modem status adds one more edge for its input sampling register. The bench drives on falling edges. After every table step it waits one extra falling edge before it compares `irq`, and each read starts at least one full cycle after the step before it. Checks on the transmit and receive handshakes sample at the falling edge that follows the capturing edge.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int NREG = 8;
  // register indices (address >> 2)
  localparam logic [2:0] IX_DATA = 3'd0;
  localparam logic [2:0] IX_ENA  = 3'd1;
  localparam logic [2:0] IX_ID   = 3'd2;
  localparam logic [2:0] IX_LCTL = 3'd3;
  localparam logic [2:0] IX_MCTL = 3'd4;
  localparam logic [2:0] IX_STAT = 3'd5;
  localparam logic [2:0] IX_MSTS = 3'd6;
  localparam logic [2:0] IX_DIV  = 3'd7;
  // enable bits
  localparam int EN_RXD = 0;
  localparam int EN_THE = 1;
  localparam int EN_ERR = 2;
  localparam int EN_MOD = 3;
  // identification codes
  localparam logic [2:0] ID_NONE = 3'b001;
  localparam logic [2:0] ID_ERR  = 3'b110;
  localparam logic [2:0] ID_RXD  = 3'b100;
  localparam logic [2:0] ID_THE  = 3'b010;
  localparam logic [2:0] ID_MOD  = 3'b000;
endpackage

// File: rtl/sport_rx_hold.sv
module sport_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic [2:0]    rx_flags,   // {break, framing, parity}
  input  logic          rd_data,
  input  logic          rd_status,
  output logic [DW-1:0] hold_q,
  output logic          ready_q,
  output logic          ovr_q,
  output logic [2:0]    flags_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      if (rx_valid) hold_q <= rx_data;
      if (rx_valid) ready_q <= 1'b1;
      else if (rd_data) ready_q <= 1'b0;
      if (rx_valid && ready_q && !rd_data) ovr_q <= 1'b1;
      else if (rd_status) ovr_q <= 1'b0;
      if (rd_status) flags_q <= rx_valid ? rx_flags : 3'b000;
      else if (rx_valid) flags_q <= flags_q | rx_flags;
    end
  end

  p_dr_set_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (ready_q && hold_q == $past(rx_data)));
  p_rd_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !rx_valid) |=> !ready_q);
  p_overrun_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && ready_q && !rd_data) |=> (ovr_q && ready_q));
  p_stat_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !rx_valid) |=> (!ovr_q && flags_q == 3'b000));
endmodule

// File: rtl/sport_tx_hold.sv
module sport_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wr_byte,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      if (wr) begin
        tx_valid <= 1'b1;
        tx_byte  <= wr_byte;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
    end
  end

  p_tx_load_r3: assert property (@(posedge clk) disable iff (rst)
    wr |=> (tx_valid && tx_byte == $past(wr_byte)));
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !wr) |=> (tx_valid && $stable(tx_byte)));
endmodule

// File: rtl/sport_irq_prio.sv
module sport_irq_prio
  import sport_pkg::*;
(
  input  logic       err_act,
  input  logic       rxd_act,
  input  logic       the_act,
  input  logic       mod_act,
  input  logic [3:0] ena,
  output logic       req,
  output logic [2:0] code
);
  always_comb begin
    req  = 1'b1;
    code = ID_NONE;
    if (err_act && ena[EN_ERR])      code = ID_ERR;
    else if (rxd_act && ena[EN_RXD]) code = ID_RXD;
    else if (the_act && ena[EN_THE]) code = ID_THE;
    else if (mod_act && ena[EN_MOD]) code = ID_MOD;
    else                             req  = 1'b0;
  end
endmodule

// File: rtl/sport_regs.sv
module sport_regs
  import sport_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_byte,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  output logic              rx_ready,
  input  logic [7:0]        modem_status,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [2:0]       sel;
  logic             hit, wr_acc, rd_acc;
  assign idx    = bus_addr[ADDR_W-1:2];
  assign sel    = idx[2:0];
  assign hit    = (idx < IDX_W'(NREG));
  assign wr_acc = bus_sel && bus_we && hit;
  assign rd_acc = bus_sel && !bus_we && hit;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:DIV_W]};

  logic [3:0]       ena_q;
  logic [7:0]       lctl_q, mctl_q, msts_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       id_q;
  logic             irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q  <= '0;
      lctl_q <= '0;
      mctl_q <= '0;
      div_q  <= '0;
      msts_q <= '0;
    end else begin
      msts_q <= modem_status;
      if (wr_acc) begin
        case (sel)
          IX_ENA:  ena_q  <= bus_wdata[3:0];
          IX_LCTL: lctl_q <= bus_wdata[7:0];
          IX_MCTL: mctl_q <= bus_wdata[7:0];
          IX_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // receive side
  logic [DW-1:0] hold_q;
  logic          dr_q, ovr_q;
  logic [2:0]    flags_q;
  sport_rx_hold #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_flags ({rx_brk, rx_ferr, rx_perr}),
    .rd_data  (rd_acc && sel == IX_DATA),
    .rd_status(rd_acc && sel == IX_STAT),
    .hold_q   (hold_q),
    .ready_q  (dr_q),
    .ovr_q    (ovr_q),
    .flags_q  (flags_q)
  );
  assign rx_ready = !dr_q;

  // transmit side
  logic [DW-1:0] wr_byte;
  assign wr_byte = bus_wdata[DW-1:0];
  sport_tx_hold #(.DW(DW)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_acc && sel == IX_DATA),
    .wr_byte (wr_byte),
    .tx_ready(tx_ready),
    .tx_valid(tx_valid),
    .tx_byte (tx_byte)
  );
  logic tx_empty;
  assign tx_empty = !tx_valid;

  logic [7:0] stat;
  assign stat = {1'b0, tx_empty, tx_empty, flags_q[2], flags_q[1], flags_q[0], ovr_q, dr_q};

  // interrupt selection
  logic       req_c;
  logic [2:0] code_c;
  sport_irq_prio u_prio (
    .err_act(ovr_q || (|flags_q)),
    .rxd_act(dr_q),
    .the_act(tx_empty),
    .mod_act(|msts_q[3:0]),
    .ena    (ena_q),
    .req    (req_c),
    .code   (code_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q  <= ID_NONE;
      irq_q <= 1'b0;
    end else begin
      id_q  <= code_c;
      irq_q <= req_c;
    end
  end
  assign irq = irq_q;

  // read path
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (sel)
        IX_DATA: rd_mux = 32'(hold_q);
        IX_ENA:  rd_mux = {28'b0, ena_q};
        IX_ID:   rd_mux = {29'b0, id_q};
        IX_LCTL: rd_mux = {24'b0, lctl_q};
        IX_MCTL: rd_mux = {24'b0, mctl_q};
        IX_STAT: rd_mux = {24'b0, stat};
        IX_MSTS: rd_mux = {24'b0, msts_q};
        IX_DIV:  rd_mux = 32'(div_q);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && !bus_we) bus_rdata <= rd_mux;
  end

  p_undef_read_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && !hit) |=> (bus_rdata == 32'b0));
  p_idcode_r9: assert property (@(posedge clk) disable iff (rst)
    (id_q == ID_NONE || id_q == ID_ERR || id_q == ID_RXD ||
     id_q == ID_THE || id_q == ID_MOD));
  p_err_first_r8: assert property (@(posedge clk) disable iff (rst)
    ((ovr_q || (|flags_q)) && ena_q[EN_ERR]) |=> (irq_q && id_q == ID_ERR));
  p_ro_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && !(hit && (sel == IX_ENA)))
      |=> (ena_q == $past(ena_q)));
endmodule

// File: tb/sport_regs_bench.sv
`timescale 1ns/1ps
module sport_regs_bench;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_sel = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              tx_valid, tx_ready = 1'b1;
  logic [7:0]        tx_byte;
  logic              rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic [7:0]        rx_data = '0;
  logic              rx_ready;
  logic [7:0]        modem_status = '0;
  logic              irq;

  always #2.5 clk = ~clk;

  sport_regs #(.ADDR_W(ADDR_W)) u_sport_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ready(rx_ready),
    .modem_status(modem_status), .irq(irq)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic rx(input logic [10:0] v);
    @(negedge clk); rx_valid = 1; rx_data = v[7:0];
    rx_perr = v[8]; rx_ferr = v[9]; rx_brk = v[10];
    @(negedge clk); rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
  endtask

  typedef enum logic [1:0] {OP_RD, OP_WR, OP_RX} op_t;
  typedef struct packed {
    op_t         op;
    logic [7:0]  addr;
    logic [31:0] data;   // write data, or rx byte with flags in bits 10:8
    logic [31:0] exp;    // expected read value
    logic        irq;    // expected irq after the step
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t TBL [NV] = '{
    '{OP_RD, 8'h14, 32'h0,    32'h60,   1'b0, 4'd1},  // R1
    '{OP_RD, 8'h08, 32'h0,    32'h01,   1'b0, 4'd1},
    '{OP_RD, 8'h04, 32'h0,    32'h00,   1'b0, 4'd1},
    '{OP_WR, 8'h04, 32'h2,    32'h0,    1'b1, 4'd8},  // R8 holding-empty only
    '{OP_RD, 8'h08, 32'h0,    32'h02,   1'b1, 4'd9},  // R9
    '{OP_WR, 8'h04, 32'h3,    32'h0,    1'b1, 4'd8},
    '{OP_RX, 8'h00, 32'h41,   32'h0,    1'b1, 4'd4},  // R4
    '{OP_RD, 8'h08, 32'h0,    32'h04,   1'b1, 4'd8},
    '{OP_RD, 8'h14, 32'h0,    32'h61,   1'b1, 4'd4},
    '{OP_RX, 8'h00, 32'h42,   32'h0,    1'b1, 4'd6},  // R6 overrun
    '{OP_WR, 8'h04, 32'h7,    32'h0,    1'b1, 4'd8},
    '{OP_RD, 8'h08, 32'h0,    32'h06,   1'b1, 4'd8},
    '{OP_RD, 8'h14, 32'h0,    32'h63,   1'b1, 4'd6},
    '{OP_RD, 8'h14, 32'h0,    32'h61,   1'b1, 4'd7},  // R7
    '{OP_RD, 8'h00, 32'h0,    32'h42,   1'b1, 4'd5},  // R5
    '{OP_RD, 8'h14, 32'h0,    32'h60,   1'b1, 4'd5},
    '{OP_RD, 8'h08, 32'h0,    32'h02,   1'b1, 4'd9},
    '{OP_RX, 8'h00, 32'h155,  32'h0,    1'b1, 4'd7},
    '{OP_RD, 8'h08, 32'h0,    32'h06,   1'b1, 4'd9},
    '{OP_RD, 8'h14, 32'h0,    32'h65,   1'b1, 4'd7},
    '{OP_RD, 8'h14, 32'h0,    32'h61,   1'b1, 4'd7},
    '{OP_RD, 8'h00, 32'h0,    32'h55,   1'b1, 4'd5},
    '{OP_RX, 8'h00, 32'h6AA,  32'h0,    1'b1, 4'd7},
    '{OP_RD, 8'h14, 32'h0,    32'h79,   1'b1, 4'd7},
    '{OP_RD, 8'h00, 32'h0,    32'hAA,   1'b1, 4'd5},
    '{OP_WR, 8'h04, 32'h8,    32'h0,    1'b0, 4'd10}, // R10 modem only, none active
    '{OP_RD, 8'h08, 32'h0,    32'h01,   1'b0, 4'd9},
    '{OP_WR, 8'h0C, 32'hA5,   32'h0,    1'b0, 4'd2},  // R2
    '{OP_RD, 8'h0C, 32'h0,    32'hA5,   1'b0, 4'd2},
    '{OP_WR, 8'h1C, 32'h1234, 32'h0,    1'b0, 4'd2},
    '{OP_RD, 8'h1C, 32'h0,    32'h1234, 1'b0, 4'd2},
    '{OP_WR, 8'h08, 32'hFF,   32'h0,    1'b0, 4'd11}, // R11
    '{OP_RD, 8'h08, 32'h0,    32'h01,   1'b0, 4'd11},
    '{OP_WR, 8'h14, 32'h0,    32'h0,    1'b0, 4'd11},
    '{OP_RD, 8'h14, 32'h0,    32'h60,   1'b0, 4'd11},
    '{OP_WR, 8'h20, 32'hFFFF, 32'h0,    1'b0, 4'd2},
    '{OP_RD, 8'h20, 32'h0,    32'h0,    1'b0, 4'd2},
    '{OP_WR, 8'h10, 32'h1F,   32'h0,    1'b0, 4'd2},
    '{OP_RD, 8'h10, 32'h0,    32'h1F,   1'b0, 4'd2},
    '{OP_RD, 8'h04, 32'h0,    32'h08,   1'b0, 4'd2}
  };

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 rx_ready", 32'(rx_ready), 32'd1);
    chk("R1 tx_valid", 32'(tx_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_RD: begin
          rd(TBL[i].addr, d);
          chk($sformatf("R%0d row %0d read", TBL[i].req, i), d, TBL[i].exp);
        end
        OP_WR: wr(TBL[i].addr, TBL[i].data);
        default: rx(TBL[i].data[10:0]);
      endcase
      @(negedge clk);  // R12: irq is due one edge after the state change
      chk($sformatf("R%0d row %0d irq", TBL[i].req, i), 32'(irq), 32'(TBL[i].irq));
    end

    // R3 transmit handshake with a stalled consumer
    wr(8'h04, 32'h2);
    tx_ready = 1'b0;
    wr(8'h00, 32'hABC5A);
    chk("R3 tx_valid", 32'(tx_valid), 32'd1);
    chk("R3 tx_byte", 32'(tx_byte), 32'h5A);
    repeat (3) @(negedge clk);
    chk("R3 held", {23'b0, tx_valid, tx_byte}, 32'h15A);
    rd(8'h14, d);
    chk("R3 status busy", d, 32'h00);
    @(negedge clk);
    chk("R8 no holding-empty irq", 32'(irq), 32'd0);
    tx_ready = 1'b1;
    @(negedge clk);
    chk("R3 accepted", 32'(tx_valid), 32'd0);
    rd(8'h14, d);
    chk("R3 status free", d, 32'h60);

    // R4 receive can-accept output
    rx(11'h033);
    chk("R4 rx_ready low", 32'(rx_ready), 32'd0);
    rd(8'h00, d);
    chk("R5 data", d, 32'h33);
    chk("R4 rx_ready high", 32'(rx_ready), 32'd1);

    // R10 modem cause, low nibble only
    wr(8'h04, 32'h8);
    @(negedge clk); modem_status = 8'h10;
    repeat (2) @(negedge clk);
    chk("R10 upper bits no irq", 32'(irq), 32'd0);
    rd(8'h18, d);
    chk("R10 readback", d, 32'h10);
    @(negedge clk); modem_status = 8'h04;
    repeat (2) @(negedge clk);
    chk("R10 irq", 32'(irq), 32'd1);
    rd(8'h08, d);
    chk("R10 id code", d, 32'h00);
    // R8: data-ready outranks modem when both enabled
    wr(8'h04, 32'h9);
    rx(11'h011);
    @(negedge clk);
    rd(8'h08, d);
    chk("R8 data over modem", d, 32'h04);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R12 watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule